// File: doc/BRIEF.md
# Config Access Address Translator

This block sits between the configuration-space requester of a PCIe root port and the fabric that reaches the port's own registers and its outbound address translation region. Each request names a bus, a device, a function and a register offset, and says whether it is a read or a 32-bit write. The block first checks that the target can exist in the fixed topology behind the port. Accesses to the root port itself on bus 0 go straight to the local register window. All other buses go to the configuration window, with the translation region reprogrammed: a type code, a target word that carries the routing ID, and an enable bit in the region control word.

Downstream, the block presents one registered access and waits for a completion pulse. Upstream, it returns one response through a valid/ready handshake. A read whose downstream access faults returns all ones instead of whatever the fabric left on its data lines. A request for a target that cannot exist never reaches the fabric. It completes at once with an error flag, and a read of that kind also returns all ones.

Top module: `cfg_xlate`

## Requirements
- R1: On bus 0 only device numbers 0 and 1 are valid, and on bus 1 only device 0 is valid. A request for any other device on those two buses raises no `dn_valid`. It completes with `rsp_err` = 1 and `rsp_rdata` = 0xFFFFFFFF for a read or 0 for a write. Buses 2 and above accept every device number.
- R2: A valid bus-0 request is issued with `dn_local` = 1, `dn_addr` = `LOCAL_BASE` + aligned offset, and `dn_type`, `dn_target` and `dn_ctrl` all 0 (translation region disabled).
- R3: A valid request on any bus other than 0 is issued with `dn_local` = 0, `dn_addr` = `CFG_BASE` + aligned offset, and `dn_ctrl` = 0x80000000 (bit 31 is the region enable).
- R4: The region type code uses 0 for memory, 2 for I/O, 4 for type-0 config and 5 for type-1 config. Bus 1 is issued with 4 and buses 2 and above are issued with 5.
- R5: In a translated access, `dn_target` holds the bus in bits [31:24], the device in [23:19] and the function in [18:16], with bits [15:0] zero.
- R6: The two low bits of the register offset are cleared before the offset is added to the window base.
- R7: When a read completes with `dn_fault` = 1, the response is 0xFFFFFFFF with `rsp_err` = 1. A read without a fault returns `dn_rdata` with `rsp_err` = 0. A write always returns 0, and `rsp_err` copies `dn_fault`.
- R8: `dn_write` and `dn_wdata` carry the request's direction and write data. `dn_valid` stays high until the cycle where `dn_done` is sampled.
- R9: `req_ready` is high only when no request is in flight. `rsp_valid` stays high with stable `rsp_rdata` and `rsp_err` until `rsp_ready` is sampled high, and then `req_ready` returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted on this edge |
| req_bus | input | 8 | Target bus number |
| req_dev | input | 5 | Target device number |
| req_fn | input | 3 | Target function number |
| req_off | input | 12 | Register byte offset |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data |
| dn_valid | output | 1 | Downstream access pending |
| dn_local | output | 1 | 1 = local register window, 0 = translated config window |
| dn_addr | output | 32 | Downstream address |
| dn_type | output | 5 | Translation region type code |
| dn_ctrl | output | 32 | Translation region control word (bit 31 enable) |
| dn_target | output | 32 | Translation target word (routing ID) |
| dn_write | output | 1 | Downstream direction |
| dn_wdata | output | 32 | Downstream write data |
| dn_done | input | 1 | Downstream completion pulse |
| dn_fault | input | 1 | Completion faulted |
| dn_rdata | input | 32 | Completion read data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken |
| rsp_rdata | output | 32 | Response read data |
| rsp_err | output | 1 | Request rejected or faulted |

## Verification
The hardest case to reach is a read whose downstream completion faults while `dn_rdata` carries a plausible value. This is the only case that can tell the all-ones substitution apart from passing the fabric's data through. The bench plays the fabric in its own tasks: it holds the access for a few cycles, then pulses `dn_done` with `dn_fault` set and a nonzero data pattern, and it keeps `rsp_ready` low for some cycles to show that the substituted value stays stable. Rejected targets are aimed at the edges of the topology rule: bus 0 device 2, bus 1 device 1, and bus 2 with a high device number, which must pass.

// File: rtl/cfg_xlate_pkg.sv
package cfg_xlate_pkg;

  typedef enum logic [4:0] {
    RT_MEM  = 5'd0,
    RT_IO   = 5'd2,
    RT_CFG0 = 5'd4,
    RT_CFG1 = 5'd5
  } region_type_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_RESP  = 2'd2
  } xl_state_e;

endpackage

// File: rtl/cfg_filter.sv
module cfg_filter #(
  parameter int BUS_W        = 8,
  parameter int DEV_W        = 5,
  parameter int BUS0_MAX_DEV = 1,
  parameter int BUS1_MAX_DEV = 0
) (
  input  logic [BUS_W-1:0] bus,
  input  logic [DEV_W-1:0] dev,
  output logic             ok
);
  localparam logic [DEV_W-1:0] LIM0 = DEV_W'(BUS0_MAX_DEV);
  localparam logic [DEV_W-1:0] LIM1 = DEV_W'(BUS1_MAX_DEV);

  always_comb begin
    ok = 1'b1;
    if (bus == BUS_W'(0) && dev > LIM0) ok = 1'b0;
    if (bus == BUS_W'(1) && dev > LIM1) ok = 1'b0;
  end
endmodule

// File: rtl/cfg_route.sv
module cfg_route
  import cfg_xlate_pkg::*;
#(
  parameter int              BUS_W      = 8,
  parameter int              DEV_W      = 5,
  parameter int              FN_W       = 3,
  parameter int              OFF_W      = 12,
  parameter int              ADDR_W     = 32,
  parameter int              CTRL_W     = 32,
  parameter int              TGT_FN_LSB = 16,
  parameter logic [ADDR_W-1:0] LOCAL_BASE = 32'h01FF_C000,
  parameter logic [ADDR_W-1:0] CFG_BASE   = 32'h01F0_0000
) (
  input  logic [BUS_W-1:0]  bus,
  input  logic [DEV_W-1:0]  dev,
  input  logic [FN_W-1:0]   fn,
  input  logic [OFF_W-1:0]  off,
  output logic              is_local,
  output logic [ADDR_W-1:0] addr,
  output logic [4:0]        rtype,
  output logic [CTRL_W-1:0] ctrl,
  output logic [TGT_FN_LSB+FN_W+DEV_W+BUS_W-1:0] target
);
  localparam int TGT_DEV_LSB = TGT_FN_LSB + FN_W;
  localparam int TGT_BUS_LSB = TGT_DEV_LSB + DEV_W;
  localparam int TGT_W       = TGT_BUS_LSB + BUS_W;

  logic [OFF_W-1:0] off_al;

  always_comb begin
    off_al   = off & ~OFF_W'(3);
    is_local = (bus == BUS_W'(0));
    target   = '0;
    ctrl     = '0;
    rtype    = 5'(RT_MEM);
    if (is_local) begin
      addr = LOCAL_BASE + ADDR_W'(off_al);
    end else begin
      addr = CFG_BASE + ADDR_W'(off_al);
      ctrl[CTRL_W-1] = 1'b1;
      rtype = (bus == BUS_W'(1)) ? 5'(RT_CFG0) : 5'(RT_CFG1);
      target[TGT_W-1:TGT_BUS_LSB]       = bus;
      target[TGT_BUS_LSB-1:TGT_DEV_LSB] = dev;
      target[TGT_DEV_LSB-1:TGT_FN_LSB]  = fn;
    end
  end
endmodule

// File: rtl/cfg_xlate.sv
module cfg_xlate
  import cfg_xlate_pkg::*;
#(
  parameter int              BUS_W        = 8,
  parameter int              DEV_W        = 5,
  parameter int              FN_W         = 3,
  parameter int              OFF_W        = 12,
  parameter int              DATA_W       = 32,
  parameter int              ADDR_W       = 32,
  parameter int              CTRL_W       = 32,
  parameter int              TGT_FN_LSB   = 16,
  parameter int              BUS0_MAX_DEV = 1,
  parameter int              BUS1_MAX_DEV = 0,
  parameter logic [ADDR_W-1:0] LOCAL_BASE = 32'h01FF_C000,
  parameter logic [ADDR_W-1:0] CFG_BASE   = 32'h01F0_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [BUS_W-1:0]  req_bus,
  input  logic [DEV_W-1:0]  req_dev,
  input  logic [FN_W-1:0]   req_fn,
  input  logic [OFF_W-1:0]  req_off,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              dn_valid,
  output logic              dn_local,
  output logic [ADDR_W-1:0] dn_addr,
  output logic [4:0]        dn_type,
  output logic [CTRL_W-1:0] dn_ctrl,
  output logic [TGT_FN_LSB+FN_W+DEV_W+BUS_W-1:0] dn_target,
  output logic              dn_write,
  output logic [DATA_W-1:0] dn_wdata,
  input  logic              dn_done,
  input  logic              dn_fault,
  input  logic [DATA_W-1:0] dn_rdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err
);
  localparam int TGT_W = TGT_FN_LSB + FN_W + DEV_W + BUS_W;

  xl_state_e         state;
  logic              tgt_ok;
  logic              r_local;
  logic [ADDR_W-1:0] r_addr;
  logic [4:0]        r_type;
  logic [CTRL_W-1:0] r_ctrl;
  logic [TGT_W-1:0]  r_target;

  cfg_filter #(
    .BUS_W(BUS_W), .DEV_W(DEV_W),
    .BUS0_MAX_DEV(BUS0_MAX_DEV), .BUS1_MAX_DEV(BUS1_MAX_DEV)
  ) u_filter (
    .bus(req_bus), .dev(req_dev), .ok(tgt_ok)
  );

  cfg_route #(
    .BUS_W(BUS_W), .DEV_W(DEV_W), .FN_W(FN_W), .OFF_W(OFF_W),
    .ADDR_W(ADDR_W), .CTRL_W(CTRL_W), .TGT_FN_LSB(TGT_FN_LSB),
    .LOCAL_BASE(LOCAL_BASE), .CFG_BASE(CFG_BASE)
  ) u_route (
    .bus(req_bus), .dev(req_dev), .fn(req_fn), .off(req_off),
    .is_local(r_local), .addr(r_addr), .rtype(r_type),
    .ctrl(r_ctrl), .target(r_target)
  );

  assign req_ready = (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      dn_valid  <= 1'b0;
      dn_local  <= 1'b0;
      dn_addr   <= '0;
      dn_type   <= '0;
      dn_ctrl   <= '0;
      dn_target <= '0;
      dn_write  <= 1'b0;
      dn_wdata  <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            dn_write <= req_write;
            if (tgt_ok) begin
              dn_valid  <= 1'b1;
              dn_local  <= r_local;
              dn_addr   <= r_addr;
              dn_type   <= r_type;
              dn_ctrl   <= r_ctrl;
              dn_target <= r_target;
              dn_wdata  <= req_wdata;
              state     <= ST_ISSUE;
            end else begin
              rsp_valid <= 1'b1;
              rsp_err   <= 1'b1;
              rsp_rdata <= req_write ? '0 : '1;
              state     <= ST_RESP;
            end
          end
        end
        ST_ISSUE: begin
          if (dn_done) begin
            dn_valid  <= 1'b0;
            rsp_valid <= 1'b1;
            rsp_err   <= dn_fault;
            if (dn_write)      rsp_rdata <= '0;
            else if (dn_fault) rsp_rdata <= '1;
            else               rsp_rdata <= dn_rdata;
            state <= ST_RESP;
          end
        end
        ST_RESP: begin
          if (rsp_ready) begin
            rsp_valid <= 1'b0;
            state     <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cfg_xlate_chk.sv
module cfg_xlate_chk #(
  parameter int BUS_W  = 8,
  parameter int DEV_W  = 5,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int CTRL_W = 32,
  parameter int TGT_W  = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              req_ready,
  input logic              dn_valid,
  input logic              dn_local,
  input logic [ADDR_W-1:0] dn_addr,
  input logic [4:0]        dn_type,
  input logic [CTRL_W-1:0] dn_ctrl,
  input logic [TGT_W-1:0]  dn_target,
  input logic              dn_done,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              rsp_err
);
  // R1
  bus1_dev_limit_chk: assert property (@(posedge clk) disable iff (rst)
    (dn_valid && !dn_local && dn_target[TGT_W-1 -: BUS_W] == BUS_W'(1))
      |-> dn_target[TGT_W-BUS_W-1 -: DEV_W] == '0);

  // R2
  local_region_off_chk: assert property (@(posedge clk) disable iff (rst)
    (dn_valid && dn_local) |-> (dn_ctrl == '0 && dn_target == '0));

  // R3
  xlate_region_on_chk: assert property (@(posedge clk) disable iff (rst)
    (dn_valid && !dn_local) |-> dn_ctrl[CTRL_W-1]);

  // R4
  cfg_type_sel_chk: assert property (@(posedge clk) disable iff (rst)
    (dn_valid && !dn_local) |->
      ((dn_type == 5'd4) == (dn_target[TGT_W-1 -: BUS_W] == BUS_W'(1)))
      && (dn_type == 5'd4 || dn_type == 5'd5));

  // R6
  dword_align_chk: assert property (@(posedge clk) disable iff (rst)
    dn_valid |-> dn_addr[1:0] == 2'b00);

  // R8
  dn_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (dn_valid && !dn_done) |=> dn_valid && $stable(dn_addr));

  // R9
  rsp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_rdata) && $stable(rsp_err));

  // R9
  one_in_flight_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({req_ready, dn_valid, rsp_valid}));
endmodule

bind cfg_xlate cfg_xlate_chk #(
  .BUS_W(BUS_W), .DEV_W(DEV_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
  .CTRL_W(CTRL_W), .TGT_W(TGT_FN_LSB + FN_W + DEV_W + BUS_W)
) u_chk (
  .clk(clk), .rst(rst), .req_ready(req_ready), .dn_valid(dn_valid),
  .dn_local(dn_local), .dn_addr(dn_addr), .dn_type(dn_type),
  .dn_ctrl(dn_ctrl), .dn_target(dn_target), .dn_done(dn_done),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
  .rsp_err(rsp_err)
);

// File: tb/cfg_xlate_test.sv
`timescale 1ns/1ps
module cfg_xlate_test;
  localparam logic [31:0] LB = 32'h01FF_C000;
  localparam logic [31:0] CB = 32'h01F0_0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [7:0]  req_bus = '0;
  logic [4:0]  req_dev = '0;
  logic [2:0]  req_fn = '0;
  logic [11:0] req_off = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, dn_valid, dn_local, dn_write, rsp_valid, rsp_err;
  logic [31:0] dn_addr, dn_ctrl, dn_target, dn_wdata, rsp_rdata;
  logic [4:0]  dn_type;
  logic dn_done = 1'b0, dn_fault = 1'b0, rsp_ready = 1'b0;
  logic [31:0] dn_rdata = '0;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  cfg_xlate uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_bus(req_bus), .req_dev(req_dev), .req_fn(req_fn), .req_off(req_off),
    .req_write(req_write), .req_wdata(req_wdata),
    .dn_valid(dn_valid), .dn_local(dn_local), .dn_addr(dn_addr),
    .dn_type(dn_type), .dn_ctrl(dn_ctrl), .dn_target(dn_target),
    .dn_write(dn_write), .dn_wdata(dn_wdata), .dn_done(dn_done),
    .dn_fault(dn_fault), .dn_rdata(dn_rdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .rsp_err(rsp_err)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // Drives one request, plays the fabric, and checks every output against
  // values derived from the requirements.
  task automatic run(input logic [7:0] bus, input logic [4:0] dev,
                     input logic [2:0] fn, input logic [11:0] off,
                     input bit wr, input logic [31:0] wd, input bit fault,
                     input logic [31:0] fab_rd, input int hold);
    bit ok_t, loc;
    logic [31:0] e_addr, e_tgt, e_ctrl, e_rd;
    logic [4:0] e_type;
    bit e_err;
    ok_t = !((bus == 0 && dev > 1) || (bus == 1 && dev > 0));
    loc  = (bus == 0);
    e_addr = (loc ? LB : CB) + {20'h0, off[11:2], 2'b00};
    e_type = loc ? 5'd0 : (bus == 1 ? 5'd4 : 5'd5);
    e_tgt  = loc ? 32'h0 : {bus, dev, fn, 16'h0};
    e_ctrl = loc ? 32'h0 : 32'h8000_0000;
    if (!ok_t) begin e_err = 1'b1; e_rd = wr ? 32'h0 : 32'hFFFF_FFFF; end
    else begin
      e_err = fault;
      e_rd  = wr ? 32'h0 : (fault ? 32'hFFFF_FFFF : fab_rd);
    end

    @(negedge clk);
    check(req_ready, "R9 idle ready", {31'h0, req_ready}, 32'h1);
    req_bus = bus; req_dev = dev; req_fn = fn; req_off = off;
    req_write = wr; req_wdata = wd; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(!req_ready, "R9 busy", {31'h0, req_ready}, 32'h0);
    if (!ok_t) begin
      check(!dn_valid, "R1 rejected not issued", {31'h0, dn_valid}, 32'h0);
    end else begin
      check(dn_valid, "R8 issued", {31'h0, dn_valid}, 32'h1);
      check(dn_local == loc, loc ? "R2 local flag" : "R3 local flag",
            {31'h0, dn_local}, {31'h0, loc});
      check(dn_addr == e_addr, "R6 address", dn_addr, e_addr);
      check(dn_type == e_type, "R4 type", {27'h0, dn_type}, {27'h0, e_type});
      check(dn_target == e_tgt, "R5 target", dn_target, e_tgt);
      check(dn_ctrl == e_ctrl, loc ? "R2 ctrl" : "R3 ctrl", dn_ctrl, e_ctrl);
      check(dn_write == wr, "R8 dir", {31'h0, dn_write}, {31'h0, wr});
      if (wr) check(dn_wdata == wd, "R8 wdata", dn_wdata, wd);
      for (int i = 0; i < 3; i++) begin
        @(negedge clk);
        check(dn_valid && !rsp_valid, "R8 hold", {31'h0, dn_valid}, 32'h1);
      end
      dn_done = 1'b1; dn_fault = fault; dn_rdata = fab_rd;
      @(negedge clk);
      dn_done = 1'b0; dn_fault = 1'b0; dn_rdata = 32'h0;
      check(!dn_valid, "R8 release", {31'h0, dn_valid}, 32'h0);
    end
    check(rsp_valid, "R9 rsp valid", {31'h0, rsp_valid}, 32'h1);
    check(rsp_rdata == e_rd, ok_t ? "R7 rdata" : "R1 rdata", rsp_rdata, e_rd);
    check(rsp_err == e_err, ok_t ? "R7 err" : "R1 err",
          {31'h0, rsp_err}, {31'h0, e_err});
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      check(rsp_valid && rsp_rdata == e_rd, "R9 rsp held", rsp_rdata, e_rd);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    check(!rsp_valid && req_ready, "R9 return idle",
          {30'h0, rsp_valid, req_ready}, 32'h1);
  endtask

  task automatic t_reset;
    check(req_ready && !dn_valid && !rsp_valid, "R9 reset state",
          {29'h0, req_ready, dn_valid, rsp_valid}, 32'h4);
  endtask
  task automatic t_local;
    run(8'd0, 5'd1, 3'd0, 12'h013, 1'b0, 32'h0, 1'b0, 32'h1234_5678, 0); // R2 R6
    run(8'd0, 5'd0, 3'd2, 12'h3FE, 1'b1, 32'hCAFE_0001, 1'b0, 32'h0, 1); // R2 R8
  endtask
  task automatic t_type0;
    run(8'd1, 5'd0, 3'd7, 12'h102, 1'b0, 32'h0, 1'b0, 32'hA5A5_0F0F, 0); // R4 R5
  endtask
  task automatic t_type1;
    run(8'd5, 5'd31, 3'd3, 12'hFFF, 1'b1, 32'h0BAD_F00D, 1'b0, 32'h0, 0); // R4 R3
    run(8'd2, 5'd9, 3'd1, 12'h041, 1'b0, 32'h0, 1'b0, 32'h0000_BEEF, 2); // R3
  endtask
  task automatic t_reject;
    run(8'd0, 5'd2, 3'd0, 12'h000, 1'b0, 32'h0, 1'b0, 32'h0, 1); // R1
    run(8'd1, 5'd1, 3'd0, 12'h010, 1'b1, 32'h1111_2222, 1'b0, 32'h0, 0); // R1
  endtask
  task automatic t_fault;
    run(8'd3, 5'd4, 3'd0, 12'h008, 1'b0, 32'h0, 1'b1, 32'h5A5A_5A5A, 3); // R7
    run(8'd1, 5'd0, 3'd0, 12'h00C, 1'b1, 32'h7, 1'b1, 32'h5A5A_5A5A, 0); // R7
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_local();
        t_type0();
        t_type1();
        t_reject();
        t_fault();
      end
      begin
        repeat (20000) @(negedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule